// File: doc/BRIEF.md
# Bidirectional Latched Serial-to-Parallel Driver Core

This block turns a serial bit stream into a wide parallel channel vector. Bits arrive on a serial data pin together with a shift clock. Each falling edge of that clock moves the shift register one stage. A direction pin selects which way the bits travel, and it can change between edges. The last stage in the chosen direction is presented on a serial output, so several of these cores can be chained and clocked together.

A holding stage sits after the shift register. While latch enable is high it follows the register. When latch enable is low it keeps its value, so new data can be shifted in while the old pattern stays on the channels. An output enable gates every channel off at once. Latch enable and output enable act only on the holding stage and on the outputs. Shifting goes on at any level of either pin.

All logic runs on one system clock. The shift clock and the other control pins are sampled through a synchronizer. The falling edge of the shift clock is then found by an edge detector.

Top module: `s2p_driver`

## Requirements
- R1: The register moves exactly one stage for each high-to-low transition of `shclk_i`. A rising edge, or a steady level, leaves it unchanged.
- R2: With `dir_i` high, each stage n passes its bit to stage n+1. The serial input enters stage 1, which is channel bit 0.
- R3: With `dir_i` low, each stage n passes its bit to stage n-1. The serial input enters stage NCH, which is channel bit NCH-1.
- R4: `sdata_o` shows the last stage for the current direction: stage NCH (bit NCH-1) when `dir_i` is high, and stage 1 (bit 0) when it is low. A pattern shifted in therefore comes out of `sdata_o` over the next NCH falling edges, in the order it went in.
- R5: While `le_i` is high, the holding stage takes the register contents every system cycle. While `le_i` is low, it keeps its value, even while shifting continues.
- R6: The levels of `le_i` and `oe_i` have no effect on the shift register or on `sdata_o`.
- R7: With `oe_i` low, every bit of `ch_o` is 0. With `oe_i` high, a bit of `ch_o` is 1 exactly when the matching holding bit is 1.
- R8: A synchronous high on `rst_i` clears the shift register, the holding stage and the synchronizer, so `ch_o` and `sdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| shclk_i | input | 1 | Shift clock; the register advances on its falling edge |
| sdata_i | input | 1 | Serial data in |
| dir_i | input | 1 | Shift direction: 1 moves toward higher stages, 0 toward lower |
| le_i | input | 1 | Latch enable: 1 makes the holding stage transparent, 0 holds it |
| oe_i | input | 1 | Output enable: 0 forces every channel off |
| sdata_o | output | 1 | Serial data out (last stage for the current direction) |
| ch_o | output | NCH | Channel outputs; bit k is stage k+1 |

## Verification
Two things are hard to reach from the ports. The first is the cascade path: the serial output must play back an earlier pattern while a second pattern is being shifted in. The second is that the holding stage must stay frozen during that whole second pass. The stimulus drives a full NCH-bit pattern in, pulses latch enable, and then clocks NCH more bits in with latch enable low. Before each edge it compares `sdata_o` against the bit the first pattern predicts, and afterwards it compares the frozen channels. A separate directed step raises the shift clock without lowering it, to show that rising edges do not shift. Another shifts with both enables low, to show that shifting ignores them.

// File: rtl/s2p_pkg.sv
package s2p_pkg;

  // Control bundle sampled together through the synchronizer
  typedef struct packed {
    logic shclk;
    logic din;
    logic dir;
    logic le;
    logic oe;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/s2p_input_sync.sv
module s2p_input_sync
  import s2p_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  ctl_t ctl_i,
  output ctl_t cur_o,
  output ctl_t prev_o,
  output logic fall_o
);

  localparam int LAST = SYNC_STAGES - 1;

  ctl_t chain_q [SYNC_STAGES];
  ctl_t prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain_q[i] <= '0;
      prev_q <= '0;
    end else begin
      chain_q[0] <= ctl_i;
      for (int i = 1; i < SYNC_STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[LAST];
    end
  end

  assign cur_o  = chain_q[LAST];
  assign prev_o = prev_q;
  // falling edge: last sample high, current sample low
  assign fall_o = prev_q.shclk & ~chain_q[LAST].shclk;

endmodule

// File: rtl/s2p_shift_reg.sv
module s2p_shift_reg #(
  parameter int NCH = 64
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           step_i,
  input  logic           step_dir_i,
  input  logic           din_i,
  input  logic           out_dir_i,
  output logic [NCH-1:0] q_o,
  output logic           sout_o
);

  localparam int TOP = NCH - 1;

  logic [NCH-1:0] q_q;
  logic [NCH-1:0] nxt;

  for (genvar g = 0; g < NCH; g++) begin : g_stage
    logic from_low;
    logic from_high;
    if (g == 0) begin : g_first
      assign from_low = din_i;
    end else begin : g_mid_lo
      assign from_low = q_q[g-1];
    end
    if (g == TOP) begin : g_last
      assign from_high = din_i;
    end else begin : g_mid_hi
      assign from_high = q_q[g+1];
    end
    assign nxt[g] = step_dir_i ? from_low : from_high;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       q_q <= '0;
    else if (step_i) q_q <= nxt;
  end

  assign q_o    = q_q;
  assign sout_o = out_dir_i ? q_q[TOP] : q_q[0];

  AST_NO_STEP_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(q_q)); // R1
  AST_FWD_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && step_dir_i) |=> (q_q[0] == $past(din_i))); // R2
  AST_REV_ENTRY: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !step_dir_i) |=> (q_q[TOP] == $past(din_i))); // R3

endmodule

// File: rtl/s2p_hold_stage.sv
module s2p_hold_stage #(
  parameter int NCH = 64
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           le_i,
  input  logic           oe_i,
  input  logic [NCH-1:0] d_i,
  output logic [NCH-1:0] ch_o
);

  logic [NCH-1:0] hold_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      hold_q <= '0;
    else if (le_i)  hold_q <= d_i;
  end

  assign ch_o = hold_q & {NCH{oe_i}};

  AST_LATCH_CLOSED: assert property (@(posedge clk_i) disable iff (rst_i)
    !le_i |=> $stable(hold_q)); // R5
  AST_LATCH_OPEN: assert property (@(posedge clk_i) disable iff (rst_i)
    le_i |=> (hold_q == $past(d_i))); // R5

endmodule

// File: rtl/s2p_driver.sv
module s2p_driver
  import s2p_pkg::*;
#(
  parameter int NCH         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           shclk_i,
  input  logic           sdata_i,
  input  logic           dir_i,
  input  logic           le_i,
  input  logic           oe_i,
  output logic           sdata_o,
  output logic [NCH-1:0] ch_o
);

  ctl_t ctl_in;
  ctl_t ctl_cur;
  ctl_t ctl_prev;
  logic fall;
  logic [NCH-1:0] stages;

  assign ctl_in = '{shclk: shclk_i, din: sdata_i, dir: dir_i, le: le_i, oe: oe_i};

  s2p_input_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .ctl_i  (ctl_in),
    .cur_o  (ctl_cur),
    .prev_o (ctl_prev),
    .fall_o (fall)
  );

  // data and direction are taken from the last sample before the edge
  s2p_shift_reg #(.NCH(NCH)) u_shift (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .step_i     (fall),
    .step_dir_i (ctl_prev.dir),
    .din_i      (ctl_prev.din),
    .out_dir_i  (ctl_cur.dir),
    .q_o        (stages),
    .sout_o     (sdata_o)
  );

  s2p_hold_stage #(.NCH(NCH)) u_hold (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .le_i  (ctl_cur.le),
    .oe_i  (ctl_cur.oe),
    .d_i   (stages),
    .ch_o  (ch_o)
  );

  AST_SINGLE_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
    fall |=> !fall); // R1
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (rst_i)
    !ctl_cur.oe |-> (ch_o == '0)); // R7

endmodule

// File: tb/s2p_driver_tb.sv
module s2p_driver_tb;

  localparam int NCH = 64;

  logic clk = 1'b0;
  logic rst, shclk, sdata, dir, le, oe;
  logic sout;
  logic [NCH-1:0] ch;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  s2p_driver #(.NCH(NCH), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_i(rst), .shclk_i(shclk), .sdata_i(sdata),
    .dir_i(dir), .le_i(le), .oe_i(oe), .sdata_o(sout), .ch_o(ch)
  );

  // stimulus table: direction and pattern; expected channels equal the pattern
  localparam logic        TDIR [4] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [63:0] TPAT [4] = '{64'hDEAD_BEEF_0123_4567,
                                       64'hDEAD_BEEF_0123_4567,
                                       64'h8000_0000_0000_0001,
                                       64'hF0F0_3C3C_A5A5_0FF1};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdata = b;
    shclk = 1'b1;
    tick(6);
    shclk = 1'b0;
    tick(6);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(1);
  endtask

  initial begin
    rst = 1'b1; shclk = 1'b0; sdata = 1'b0; dir = 1'b1; le = 1'b0; oe = 1'b0;
    do_reset();
    le = 1'b1; oe = 1'b1;
    tick(6);
    chk("R8 reset channels", 64'(ch), 64'h0);
    chk("R8 reset sout", 64'(sout), 64'h0);

    // R1: rising edge alone does not shift
    sdata = 1'b1; shclk = 1'b1;
    tick(8);
    chk("R1 rising edge no shift", 64'(ch), 64'h0);
    shclk = 1'b0;
    tick(8);
    chk("R1 R2 falling edge shifts into bit0", 64'(ch), 64'h1);

    // R6: shift with both enables low, then open and inspect
    le = 1'b0; oe = 1'b0;
    tick(6);
    chk("R7 oe low forces off", 64'(ch), 64'h0);
    shift_bit(1'b1);
    le = 1'b1; oe = 1'b1;
    tick(6);
    chk("R6 shift unaffected by le/oe", 64'(ch), 64'h3);

    // R3: reverse entry at top stage
    do_reset();
    dir = 1'b0;
    tick(6);
    shift_bit(1'b1);
    chk("R3 reverse entry at top", 64'(ch), 64'h8000_0000_0000_0000);
    chk("R4 reverse sout is stage1", 64'(sout), 64'h0);
    le = 1'b0;

    // table walk
    for (int t = 0; t < 4; t++) begin
      dir = TDIR[t];
      le = 1'b0; oe = 1'b1;
      tick(6);
      for (int k = 0; k < NCH; k++)
        shift_bit(TDIR[t] ? TPAT[t][NCH-1-k] : TPAT[t][k]);
      le = 1'b1; tick(6); le = 1'b0; tick(6);
      chk(TDIR[t] ? "R2 fwd pattern" : "R3 rev pattern", ch, TPAT[t]);
      // cascade: shift zeros, first pattern must emerge on sout
      for (int k = 0; k < NCH; k++) begin
        chk("R4 cascade sout", 64'(sout),
            64'(TDIR[t] ? TPAT[t][NCH-1-k] : TPAT[t][k]));
        shift_bit(1'b0);
      end
      chk("R5 hold while le low", ch, TPAT[t]);
      oe = 1'b0; tick(6);
      chk("R7 oe low all off", ch, 64'h0);
      oe = 1'b1; tick(6);
      chk("R7 oe high shows hold", ch, TPAT[t]);
      le = 1'b1; tick(6);
      chk("R5 transparent shows cleared register", ch, 64'h0);
    end

    // reset after activity
    shift_bit(1'b1);
    do_reset();
    tick(6);
    chk("R8 reset after activity", ch, 64'h0);
    chk("R8 reset sout after activity", 64'(sout), 64'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule